// File: doc/BRIEF.md
# Immediate Word Load/Store Unit

This unit executes the two descriptor commands that move a single small value between system memory and the descriptor's 32-bit immediate word. A sequencer hands it one command at a time with a start pulse, the raw request count, the address, the stream key, the current immediate word and the current command pointer. The unit picks a transfer size of 1, 2 or 4 bytes from the low count bits, aligns the address to match, and issues one access on a byte-enabled 32-bit memory port.

A load merges the fetched bytes into the top of the immediate word. A store shifts the immediate word down to the requested size and places it on the proper little-endian byte lanes. When the access completes, the unit pulses `done` with the new immediate word. If the sequencer's wait condition is clear at that moment, it also reports a commit: status write-back, flush clear and interrupt evaluation may proceed, and the pointer moves to the next descriptor. These commands never branch. A key that does not resolve to system space ends the command at once with a kill indication and no memory traffic.

Top module: `imm_word_unit`

## Requirements
- R1: Only count bits 2:0 are used. Bit 2 set gives size 4 with address bits 1:0 cleared. Otherwise bit 1 set gives size 2 with address bit 0 cleared. Otherwise the size is 1. `mem_addr` carries the aligned address, and `mem_be` enables `size` consecutive lanes starting at lane `addr[1:0]`, where lane n is bits 8n+7:8n.
- R2: A load of size 4 returns the loaded word. Size 2 puts the loaded halfword in bits 31:16 and keeps bits 15:0 of the old immediate word. Size 1 puts the loaded byte in bits 31:24 and keeps bits 23:0.
- R3: A store writes the immediate word shifted right by 0, 16 or 24 bits for size 4, 2 or 1. The result is shifted left by 8·`addr[1:0]` onto the enabled lanes, with `mem_we` high. A store returns the immediate word unchanged.
- R4: Keys 0 to 4 are treated as the system key (6). Key 5 and key 7 kill the command: one cycle after start, `done` and `kill` are high together, no memory request is made, and `next_ptr` equals the command pointer.
- R5: If `wait_req` is low on the cycle `mem_ack` is accepted, `commit` pulses with `done` and `next_ptr` is the command pointer plus 16. If it is high, `commit` stays low and `next_ptr` equals the command pointer, but `imm_out` is still updated.
- R6: `done` is high for exactly the cycle after the one in which `mem_ack` is accepted. `mem_req` stays high with a stable address from the cycle after start until that acknowledge.
- R7: A load takes data only from the enabled lanes. Bytes of `mem_rdata` on other lanes do not affect `imm_out`.
- R8: A start pulse while an access is outstanding is ignored. A start during the `done` cycle is accepted.
- R9: After reset, `done`, `kill`, `commit`, `mem_req` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command start pulse from the sequencer |
| is_store | input | 1 | 1 = store command, 0 = load command |
| key | input | 3 | Stream key of the descriptor |
| req_count | input | 16 | Raw request count (bits 2:0 used) |
| addr | input | AW | Memory address from the descriptor |
| imm_in | input | 32 | Current immediate word |
| cmd_ptr | input | AW | Current command pointer |
| wait_req | input | 1 | Wait condition from the sequencer |
| done | output | 1 | Command finished (one-cycle pulse) |
| kill | output | 1 | Command rejected, channel must die |
| commit | output | 1 | Not waiting: write back, clear flush, evaluate interrupt |
| imm_out | output | 32 | Updated immediate word |
| next_ptr | output | AW | Command pointer after this command |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Aligned memory address |
| mem_be | output | 4 | Byte lane enables, little-endian |
| mem_wdata | output | 32 | Store data on its lanes |
| mem_rdata | input | 32 | Load data |
| mem_ack | input | 1 | Memory access complete |

## Verification
The `done` pulse of one command and the start of the next can fall in the same cycle. The bench provokes this by raising `start` with fresh operands on the very cycle it first sees `done`. It checks that the new command's memory request appears on the following cycle with the new operands, while the finishing command's `imm_out` and `next_ptr` are intact. The bench also raises a killing start while an access is outstanding, to show that the busy path takes priority. A behavioural model predicts every output on every cycle, and the memory responder fills the unused lanes with distinct bytes so that any lane mix-up becomes visible.

// File: rtl/imm_word_unit.sv
module imm_word_unit #(
  parameter int AW       = 32,
  parameter int KEY_SYS  = 6,
  parameter int KEY_REG  = 5,
  parameter int PTR_STEP = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_store,
  input  logic [2:0]    key,
  input  logic [15:0]   req_count,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   imm_in,
  input  logic [AW-1:0] cmd_ptr,
  input  logic          wait_req,
  output logic          done,
  output logic          kill,
  output logic          commit,
  output logic [31:0]   imm_out,
  output logic [AW-1:0] next_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_ack
);

  logic          busy, op_st, s4_r, s2_r;
  logic [AW-1:0] a_r, ptr_r;
  logic [31:0]   imm_r;

  wire       in_s4  = req_count[2];
  wire       in_s2  = !req_count[2] && req_count[1];
  wire [2:0] key_ef = (key < 3'(KEY_REG)) ? 3'(KEY_SYS) : key;
  wire       key_ok = (key_ef == 3'(KEY_SYS));
  wire [AW-1:0] in_al = in_s4 ? {addr[AW-1:2], 2'b00} :
                        in_s2 ? {addr[AW-1:1], 1'b0}  : addr;

  wire [1:0]  lane = a_r[1:0];
  wire [4:0]  bsh  = {lane, 3'b000};
  wire [31:0] st_v = s4_r ? imm_r : s2_r ? {16'h0, imm_r[31:16]} : {24'h0, imm_r[31:24]};
  wire [31:0] rsh  = mem_rdata >> bsh;
  wire [31:0] ld_v = s4_r ? rsh : s2_r ? {rsh[15:0], imm_r[15:0]} : {rsh[7:0], imm_r[23:0]};

  assign mem_req   = busy;
  assign mem_we    = busy && op_st;
  assign mem_addr  = a_r;
  assign mem_be    = s4_r ? 4'hF : s2_r ? (4'b0011 << lane) : (4'b0001 << lane);
  assign mem_wdata = st_v << bsh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; op_st <= 1'b0; s4_r <= 1'b0; s2_r <= 1'b0;
      a_r <= '0; ptr_r <= '0; imm_r <= '0;
      done <= 1'b0; kill <= 1'b0; commit <= 1'b0;
      imm_out <= '0; next_ptr <= '0;
    end else begin
      done <= 1'b0; kill <= 1'b0; commit <= 1'b0;
      if (busy) begin
        if (mem_ack) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          commit   <= !wait_req;
          imm_out  <= op_st ? imm_r : ld_v;
          next_ptr <= wait_req ? ptr_r : ptr_r + AW'(PTR_STEP);
        end
      end else if (start) begin
        if (key_ok) begin
          busy  <= 1'b1;
          op_st <= is_store;
          s4_r  <= in_s4;
          s2_r  <= in_s2;
          a_r   <= in_al;
          imm_r <= imm_in;
          ptr_r <= cmd_ptr;
        end else begin
          done     <= 1'b1;
          kill     <= 1'b1;
          imm_out  <= imm_in;
          next_ptr <= cmd_ptr;
        end
      end
    end
  end

  p_kill_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> done && !commit && !mem_req);

  p_done_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !kill) |-> $past(mem_req && mem_ack));

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_be));

  p_be_size_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || mem_be == 4'b0011 ||
                 mem_be == 4'b1100 || mem_be == 4'hF));

  p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be == 4'hF) |-> mem_addr[1:0] == 2'b00);

  p_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> done && next_ptr == $past(ptr_r) + AW'(PTR_STEP));

endmodule

// File: tb/tb_imm_word_unit.sv
module tb_imm_word_unit;
  logic        clk = 0, rst_n = 0;
  logic        start = 0, is_store = 0, wait_req = 0, mem_ack = 0;
  logic [2:0]  key = 0;
  logic [15:0] req_count = 0;
  logic [31:0] addr = 0, imm_in = 0, cmd_ptr = 0, mem_rdata = 0;
  logic        done, kill, commit, mem_req, mem_we;
  logic [31:0] imm_out, next_ptr, mem_addr, mem_wdata;
  logic [3:0]  mem_be;

  int n_cmp = 0, n_bad = 0, lat = 0, cnt = 0, cyc = 0;
  bit armed = 0;

  always #10 clk = ~clk;

  imm_word_unit dut (.clk(clk), .rst_n(rst_n), .start(start), .is_store(is_store), .key(key),
    .req_count(req_count), .addr(addr), .imm_in(imm_in), .cmd_ptr(cmd_ptr), .wait_req(wait_req),
    .done(done), .kill(kill), .commit(commit), .imm_out(imm_out), .next_ptr(next_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

  // behavioural reference
  bit        m_busy, m_st, e_done, e_kill, e_commit;
  int        m_size;
  logic [31:0] m_addr, m_imm, m_ptr, e_imm, e_ptr;

  function automatic int size_of(logic [15:0] c);
    if (c & 16'd4) return 4;
    if (c & 16'd2) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; e_done <= 0; e_kill <= 0; e_commit <= 0; e_imm <= 0; e_ptr <= 0;
      armed <= 1;
    end else begin
      e_done <= 0; e_kill <= 0; e_commit <= 0;
      if (m_busy) begin
        if (mem_ack) begin
          logic [63:0] got, keep;
          int off;
          off  = m_addr % 4;
          got  = ({32'h0, mem_rdata} >> (8*off)) & ((64'd1 << (8*m_size)) - 1);
          keep = (64'd1 << (8*(4-m_size))) - 1;
          m_busy <= 0; e_done <= 1; e_commit <= !wait_req;
          e_imm <= m_st ? m_imm : 32'((got << (8*(4-m_size))) | ({32'h0, m_imm} & keep));
          e_ptr <= wait_req ? m_ptr : m_ptr + 16;
        end
      end else if (start) begin
        int k;
        k = (key <= 4) ? 6 : int'(key);
        if (k == 6) begin
          int sz;
          sz = size_of(req_count);
          m_busy <= 1; m_st <= is_store; m_size <= sz;
          m_addr <= addr - (addr % sz); m_imm <= imm_in; m_ptr <= cmd_ptr;
        end else begin
          e_done <= 1; e_kill <= 1; e_imm <= imm_in; e_ptr <= cmd_ptr;
        end
      end
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (armed) begin
    cyc++;
    cmp("R6 done", 32'(done), 32'(e_done));
    cmp("R4 kill", 32'(kill), 32'(e_kill));
    cmp("R5 commit", 32'(commit), 32'(e_commit));
    cmp("R2 R7 imm_out", imm_out, e_imm);
    cmp("R5 next_ptr", next_ptr, e_ptr);
    cmp("R8 mem_req", 32'(mem_req), 32'(m_busy));
    if (m_busy) begin
      logic [63:0] v;
      cmp("R1 mem_addr", mem_addr, m_addr);
      cmp("R1 mem_be", 32'(mem_be), 32'(((1 << m_size) - 1) << (m_addr % 4)));
      cmp("R3 mem_we", 32'(mem_we), 32'(m_st));
      v = {32'h0, m_imm} >> (8*(4-m_size));
      if (m_st) cmp("R3 mem_wdata", mem_wdata, 32'(v << (8*(m_addr % 4))));
    end
  end

  // memory responder: distinct bytes on every lane
  always @(negedge clk) begin
    mem_ack <= 0;
    if (rst_n && mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack <= 1; cnt = 0;
        mem_rdata <= {mem_addr[7:0] ^ 8'hD4, mem_addr[7:0] ^ 8'h93,
                      mem_addr[7:0] ^ 8'h5B, mem_addr[7:0] ^ 8'h27};
      end else cnt++;
    end
  end

  task automatic issue(bit st, logic [2:0] k, logic [15:0] c, logic [31:0] a,
                       logic [31:0] im, logic [31:0] p, bit w, int l);
    is_store = st; key = k; req_count = c; addr = a; imm_in = im; cmd_ptr = p;
    wait_req = w; lat = l; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic run(bit st, logic [2:0] k, logic [15:0] c, logic [31:0] a,
                     logic [31:0] im, logic [31:0] p, bit w, int l);
    issue(st, k, c, a, im, p, w, l);
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    cmp("R9 reset done", 32'(done), 0);
    cmp("R9 reset mem_req", 32'(mem_req | mem_we | kill | commit), 0);
    rst_n = 1;
    @(negedge clk);
    // R1 R2 R7 loads, several sizes and offsets, upper count bits set
    run(0, 6, 16'hFFF5, 32'h1003, 32'h11223344, 32'h200, 0, 0);
    run(0, 6, 16'h0006, 32'h1006, 32'hA5A5A5A5, 32'h210, 0, 2);
    run(0, 6, 16'h0003, 32'h1003, 32'hCAFEF00D, 32'h220, 0, 1);
    run(0, 6, 16'h0002, 32'h1000, 32'hCAFEF00D, 32'h230, 0, 0);
    for (int o = 0; o < 4; o++) run(0, 6, 16'h0000, 32'h1040 + o, 32'h01234567, 32'h300, 0, o);
    for (int o = 0; o < 4; o++) run(0, 6, 16'hFFF8, 32'h1080 + o, 32'h89ABCDEF, 32'h310, 0, 0);
    // R3 stores
    for (int o = 0; o < 4; o++) begin
      run(1, 6, 16'h0001, 32'h2000 + o, 32'hDEADBEEF, 32'h400, 0, 1);
      run(1, 6, 16'h000A, 32'h2000 + o, 32'hDEADBEEF, 32'h410, 0, 0);
      run(1, 6, 16'h0004, 32'h2000 + o, 32'hDEADBEEF, 32'h420, 0, 2);
    end
    // R4 all keys
    for (int k = 0; k < 8; k++) run(k[0], 3'(k), 16'h0002, 32'h3002, 32'h5A5A0F0F, 32'h500, 0, 1);
    // R5 wait held
    run(0, 6, 16'h0002, 32'h1002, 32'h77778888, 32'h600, 1, 0);
    run(1, 3, 16'h0001, 32'h1001, 32'h77778888, 32'h610, 1, 3);
    // R8 start while busy (killing key) is ignored
    issue(0, 6, 16'h0004, 32'h1100, 32'h0, 32'h700, 0, 5);
    issue(0, 7, 16'h0001, 32'h9999, 32'hFFFFFFFF, 32'h999, 0, 5);
    while (!done) @(negedge clk);
    @(negedge clk);
    // R8 start in the done cycle is accepted
    issue(0, 6, 16'h0002, 32'h1202, 32'h13572468, 32'h800, 0, 2);
    while (!done) @(negedge clk);
    issue(1, 0, 16'h0001, 32'h1302, 32'hFEDCBA98, 32'h810, 0, 1);
    while (!done) @(negedge clk);
    issue(0, 5, 16'h0001, 32'h1400, 32'h0BADF00D, 32'h820, 0, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule